// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Generator

This block turns an interrupt request into one message-signalled interrupt write: a 64-bit destination address and a 32-bit data word. A request comes from one of several interrupt sources, or from software asking for a message directly. For a source, the block reads the source's target word. The target word holds a hart index, a guest index and an identity number. The hart index is split into a group part and a local part. Those two parts and the guest index are then placed into a page number, using field widths and shifts that are set at run time in a high configuration word. A low configuration word gives the base page.

Two configuration pairs are kept, one for the machine level and one for the supervisor level. A parameter chooses which pair this instance uses. A lock bit in the machine-level high word freezes all four configuration words until reset. The message is presented on a valid/ready output. The bus master that performs the write lives outside the block. So does the pending/enable state of each source: the block only pulses a clear line for the source it has just served.

Top module: `msi_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `msg_valid`, `src_clr` and `gen_word` are zero and all four configuration words are zero.
- R2: The high configuration word uses these fields: bit 31 is the lock; bits 28:24 are the group shift (5 bits); bits 22:20 are the hart shift (3 bits); bits 18:16 are the group width (3 bits); bits 15:12 are the hart width (4 bits); bits 11:0 are the upper 12 bits of the base page. Bits 30, 29, 23 and 19 are stored as zero and have no effect. `cfg_sel` selects the word written: 0 is machine low, 1 is machine high, 2 is supervisor low, 3 is supervisor high.
- R3: While bit 31 of the machine high word is set, writes to all four configuration words are ignored.
- R4: The address is computed as follows. The group is the hart index shifted right by the hart width. The local hart is the hart index kept to its low hart-width bits. The page number is the OR of four terms: the 44-bit base (high bits 11:0 above the 32-bit low word); the group kept to group-width bits and shifted left by group shift + 12; the local hart shifted left by the hart shift; and the guest index kept to its low hart-shift bits. The address is that page number shifted left by 12.
- R5: The target word carries the hart index in bits 31:18, the guest index in bits 17:12 and the identity number in bits 10:0. `msg_data` is the 11-bit identity number, zero-extended to 32 bits.
- R6: With `MACHINE_LEVEL`=1 the guest index is forced to zero and the machine configuration pair is used. With `MACHINE_LEVEL`=0 the guest index comes from the target word and the supervisor configuration pair is used.
- R7: A source is served only when `dom_ie`, its enable and its pending bit are all 1. Among eligible sources the lowest index wins. In the cycle its message is loaded, the block pulses that source's bit of `src_clr` (one-hot).
- R8: A software message write stores its value in `gen_word` with bits 17:12 cleared. It then sends a message to the hart in bits 31:18, with guest index zero and the identity number from bits 10:0. A pending software message is served before any source.
- R9: While `msg_valid` is 1 and `msg_ready` is 0, the address, the data and `msg_valid` hold. No new request is taken and no `src_clr` is pulsed until the message is accepted. A message loads one clock after its request is seen.
- R10: A software message stays requested until it is loaded. A second software write before that replaces it, so only the last value is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 2 | Configuration word select (R2) |
| cfg_wdata | input | 32 | Configuration write value |
| dom_ie | input | 1 | Domain interrupt enable |
| src_pend | input | NUM_SRC | Pending bit per source |
| src_en | input | NUM_SRC | Enable bit per source |
| src_target | input | NUM_SRC*32 | Target word per source, source i at bits 32i+31:32i |
| src_clr | output | NUM_SRC | One-hot pulse clearing the served source's pending bit |
| gen_we | input | 1 | Software message write strobe |
| gen_wdata | input | 32 | Software message value |
| gen_word | output | 32 | Stored software message value |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message taken by the bus master |
| msg_addr | output | 64 | Message destination address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds two copies with eight sources each. One copy is machine-level and the other is supervisor-level; they share all inputs. With both present, a single run shows the forced-zero guest field next to the guest field taken from the target word. It also shows the two configuration pairs being chosen independently, including when the machine lock freezes both. Eight sources are enough to exercise lowest-index ordering, several pending at once, and a software message overtaking them. Several high-word patterns move the group, local-hart and guest fields across their full width and shift ranges.

// File: rtl/msi_pkg.sv
// Shared constants and types for the message-signalled interrupt address generator.
// Assumes 32-bit configuration and target words; field positions are fixed by R2 and R5.
package msi_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 64;
    localparam int HART_W     = 14;
    localparam int HART_LSB   = 18;
    localparam int GUEST_W    = 6;
    localparam int GUEST_LSB  = 12;
    localparam int EIID_W     = 11;
    localparam int PAGE_SHIFT = 12;

    // Bits of the high configuration word that are kept on a write.
    localparam logic [WORD_W-1:0] HI_KEEP   = 32'h9F77_FFFF;
    // Clears the guest field of a software message value.
    localparam logic [WORD_W-1:0] GUEST_CLR = 32'hFFFC_0FFF;

    typedef enum logic [1:0] {
        CFG_M_LO = 2'd0,
        CFG_M_HI = 2'd1,
        CFG_S_LO = 2'd2,
        CFG_S_HI = 2'd3
    } cfg_slot_e;

    typedef struct packed {
        logic       lock;
        logic [4:0] grp_shift;
        logic [2:0] hart_shift;
        logic [2:0] grp_width;
        logic [3:0] hart_width;
        logic [11:0] base_top;
    } hicfg_t;

    // Pull the layout fields out of a stored high configuration word.
    function automatic hicfg_t unpack_hi(input logic [WORD_W-1:0] w);
        hicfg_t h;
        h.lock       = w[31];
        h.grp_shift  = w[28:24];
        h.hart_shift = w[22:20];
        h.grp_width  = w[18:16];
        h.hart_width = w[15:12];
        h.base_top   = w[11:0];
        return h;
    endfunction

endpackage

// File: rtl/msi_cfg_bank.sv
// Holds the four address configuration words and hands the pair that belongs to
// this domain level to the address composer.
// Assumes the lock lives in the machine high word and freezes all four words.
module msi_cfg_bank
    import msi_pkg::*;
#(
    parameter bit MACHINE_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] base_lo,
    output hicfg_t            layout,
    output logic              locked
);

    localparam int NUM_SLOTS = 4;

    logic [WORD_W-1:0] slot_q [NUM_SLOTS];

    assign locked = slot_q[int'(CFG_M_HI)][31];

    // Store a configuration word unless the machine lock is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else if (wr_en && !locked) begin
            slot_q[wr_slot] <= wr_slot[0] ? (wr_data & HI_KEEP) : wr_data;
        end
    end

    // Pick the configuration pair of this domain level.
    generate
        if (MACHINE_LEVEL) begin : g_machine
            assign base_lo = slot_q[int'(CFG_M_LO)];
            assign layout  = unpack_hi(slot_q[int'(CFG_M_HI)]);
        end else begin : g_super
            assign base_lo = slot_q[int'(CFG_S_LO)];
            assign layout  = unpack_hi(slot_q[int'(CFG_S_HI)]);
        end
    endgenerate

    logic unused_slots;
    assign unused_slots = ^{slot_q[0], slot_q[1], slot_q[2], slot_q[3]};

endmodule

// File: rtl/msi_src_pick.sv
// Chooses the lowest-index source that is allowed, enabled and pending, and
// returns a one-hot grant with that source's target word.
// Assumes NUM_SRC >= 2; purely combinational.
module msi_src_pick
    import msi_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                      allow,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC*WORD_W-1:0] targets,
    output logic                      found,
    output logic [NUM_SRC-1:0]        grant,
    output logic [WORD_W-1:0]         tgt
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] elig;
    logic [IDX_W-1:0]   idx;

    // One eligibility term per source.
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
            assign elig[g] = allow & pend[g] & en[g];
        end
    endgenerate

    // Lowest eligible index wins.
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign found = |elig;
    assign grant = found ? (NUM_SRC'(1) << idx) : '0;
    assign tgt   = targets[int'(idx)*WORD_W +: WORD_W];

endmodule

// File: rtl/msi_addr_compose.sv
// Builds the 64-bit destination address from the base page, the runtime field
// layout, a hart index and a guest index.
// Assumes the caller has already forced the guest index where required.
module msi_addr_compose
    import msi_pkg::*;
(
    input  hicfg_t             layout,
    input  logic [WORD_W-1:0]  base_lo,
    input  logic [HART_W-1:0]  hart,
    input  logic [GUEST_W-1:0] guest,
    output logic [ADDR_W-1:0]  addr
);

    logic [ADDR_W-1:0] hart_x;
    logic [ADDR_W-1:0] grp;
    logic [ADDR_W-1:0] loc;
    logic [ADDR_W-1:0] grp_keep;
    logic [ADDR_W-1:0] loc_keep;
    logic [ADDR_W-1:0] gst_keep;
    logic [ADDR_W-1:0] page;
    logic [5:0]        grp_pos;

    // Split the hart index and place every field into the page number.
    always_comb begin
        hart_x   = {{(ADDR_W-HART_W){1'b0}}, hart};
        loc_keep = (ADDR_W'(1) << layout.hart_width) - ADDR_W'(1);
        grp_keep = (ADDR_W'(1) << layout.grp_width) - ADDR_W'(1);
        gst_keep = (ADDR_W'(1) << layout.hart_shift) - ADDR_W'(1);
        grp      = hart_x >> layout.hart_width;
        loc      = hart_x & loc_keep;
        grp_pos  = {1'b0, layout.grp_shift} + 6'(PAGE_SHIFT);
        page     = {20'd0, layout.base_top, base_lo}
                 | ((grp & grp_keep) << grp_pos)
                 | (loc << layout.hart_shift)
                 | ({{(ADDR_W-GUEST_W){1'b0}}, guest} & gst_keep);
        addr     = page << PAGE_SHIFT;
    end

    logic unused_lock;
    assign unused_lock = layout.lock;

endmodule

// File: rtl/msi_addr_gen.sv
// Top of the message-signalled interrupt address generator. Takes a software
// message request or the best eligible source, composes address and data, and
// holds them on a valid/ready output until accepted.
// Assumes source pending/enable state is kept outside and cleared by src_clr.
module msi_addr_gen
    import msi_pkg::*;
#(
    parameter int NUM_SRC       = 8,
    parameter bit MACHINE_LEVEL = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_sel,
    input  logic [31:0]               cfg_wdata,
    input  logic                      dom_ie,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC*32-1:0]     src_target,
    output logic [NUM_SRC-1:0]        src_clr,
    input  logic                      gen_we,
    input  logic [31:0]               gen_wdata,
    output logic [31:0]               gen_word,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [63:0]               msg_addr,
    output logic [31:0]               msg_data
);

    logic [WORD_W-1:0]  gen_q;
    logic               gen_req_q;
    logic               vld_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  data_q;

    logic               slot_free;
    logic               take_gen;
    logic               pick_found;
    logic [WORD_W-1:0]  pick_tgt;
    logic [WORD_W-1:0]  sel_word;
    logic [GUEST_W-1:0] sel_guest;
    logic [ADDR_W-1:0]  next_addr;
    logic [WORD_W-1:0]  cfg_lo;
    hicfg_t             cfg_hi;
    logic               cfg_locked;

    assign slot_free = !vld_q || msg_ready;
    assign take_gen  = slot_free && gen_req_q;

    msi_cfg_bank #(
        .MACHINE_LEVEL (MACHINE_LEVEL)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_slot (cfg_sel),
        .wr_data (cfg_wdata),
        .base_lo (cfg_lo),
        .layout  (cfg_hi),
        .locked  (cfg_locked)
    );

    msi_src_pick #(
        .NUM_SRC (NUM_SRC)
    ) u_pick (
        .allow   (slot_free && !gen_req_q && dom_ie),
        .pend    (src_pend),
        .en      (src_en),
        .targets (src_target),
        .found   (pick_found),
        .grant   (src_clr),
        .tgt     (pick_tgt)
    );

    assign sel_word = take_gen ? gen_q : pick_tgt;

    // Guest index: forced to zero at machine level and for software messages.
    generate
        if (MACHINE_LEVEL) begin : g_guest_zero
            assign sel_guest = '0;
        end else begin : g_guest_tgt
            assign sel_guest = take_gen ? '0 : sel_word[GUEST_LSB +: GUEST_W];
        end
    endgenerate

    msi_addr_compose u_compose (
        .layout  (cfg_hi),
        .base_lo (cfg_lo),
        .hart    (sel_word[HART_LSB +: HART_W]),
        .guest   (sel_guest),
        .addr    (next_addr)
    );

    // Software message value, stored with its guest field cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else if (gen_we) begin
            gen_q <= gen_wdata & GUEST_CLR;
        end
    end

    // Software request flag: set by a write, dropped once the message loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_req_q <= 1'b0;
        end else if (gen_we) begin
            gen_req_q <= 1'b1;
        end else if (take_gen) begin
            gen_req_q <= 1'b0;
        end
    end

    // Output slot: load when empty or accepted, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else if (slot_free) begin
            vld_q <= take_gen || pick_found;
            if (take_gen || pick_found) begin
                addr_q <= next_addr;
                data_q <= {{(WORD_W-EIID_W){1'b0}}, sel_word[EIID_W-1:0]};
            end
        end
    end

    assign gen_word  = gen_q;
    assign msg_valid = vld_q;
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;

    logic unused_bits;
    assign unused_bits = ^{sel_word[11], cfg_locked};

endmodule

// File: rtl/msi_addr_gen_chk.sv
// Assertion checker for msi_addr_gen, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module msi_addr_gen_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dom_ie,
    input logic [NUM_SRC-1:0] src_pend,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_SRC-1:0] src_clr,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R9

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_clr)); // R7

    AST_CLR_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_clr) |-> dom_ie && (|(src_clr & src_pend & src_en))); // R7

    AST_CLR_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_clr) |-> (!msg_valid || msg_ready)); // R9

    AST_CLR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_clr) |=> msg_valid); // R7

    AST_DATA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_data[31:11] == 21'd0); // R5

    AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_addr[11:0] == 12'd0); // R4

    logic unused_hi;
    assign unused_hi = ^msg_addr[63:12];

endmodule

bind msi_addr_gen msi_addr_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dom_ie    (dom_ie),
    .src_pend  (src_pend),
    .src_en    (src_en),
    .src_clr   (src_clr),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
);

// File: tb/sim_msi_addr_gen.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, compared with two instances every clock.
module sim_msi_addr_gen;

    localparam int NS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic dom_ie = 1'b0;
    logic [NS-1:0] src_en = '0;
    logic [NS-1:0] pend = '0;
    logic [NS-1:0] set_req = '0;
    logic [31:0] tgt [NS];
    logic [NS*32-1:0] tgt_flat;
    logic gen_we = 1'b0;
    logic [31:0] gen_wdata = '0;
    logic msg_ready = 1'b1;

    logic [NS-1:0] clr0, clr1;
    logic [31:0] gw0, gw1, d0, d1;
    logic v0, v1;
    logic [63:0] a0, a1;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) tgt_flat[i*32 +: 32] = tgt[i];
    end

    msi_addr_gen #(.NUM_SRC(NS), .MACHINE_LEVEL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dom_ie(dom_ie), .src_pend(pend), .src_en(src_en), .src_target(tgt_flat),
        .src_clr(clr0), .gen_we(gen_we), .gen_wdata(gen_wdata), .gen_word(gw0),
        .msg_valid(v0), .msg_ready(msg_ready), .msg_addr(a0), .msg_data(d0));

    msi_addr_gen #(.NUM_SRC(NS), .MACHINE_LEVEL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dom_ie(dom_ie), .src_pend(pend), .src_en(src_en), .src_target(tgt_flat),
        .src_clr(clr1), .gen_we(gen_we), .gen_wdata(gen_wdata), .gen_word(gw1),
        .msg_valid(v1), .msg_ready(msg_ready), .msg_addr(a1), .msg_data(d1));

    // ---------------- reference model ----------------
    logic [31:0] mc [4];
    logic [31:0] m_gen;
    bit m_genreq, m_valid;
    longint unsigned m_a0, m_a1;
    logic [31:0] m_d;

    function automatic longint unsigned compose(logic [31:0] hi, logic [31:0] lo, int hart, int guest);
        int hw = int'(hi[15:12]);
        int gw = int'(hi[18:16]);
        int hs = int'(hi[22:20]);
        int gs = int'(hi[28:24]);
        longint unsigned grp = longint'(hart) / (longint'(1) << hw);
        longint unsigned loc = longint'(hart) % (longint'(1) << hw);
        longint unsigned pg;
        pg = (longint'(hi[11:0]) << 32) + longint'(lo);
        pg = pg | ((grp % (longint'(1) << gw)) << (gs + 12));
        pg = pg | (loc << hs);
        pg = pg | (longint'(guest) % (longint'(1) << hs));
        return pg << 12;
    endfunction

    function automatic int pick_src();
        if (!(!m_valid || msg_ready) || m_genreq || !dom_ie) return -1;
        for (int i = 0; i < NS; i++) if (pend[i] && src_en[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        int s;
        s = pick_src();
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) mc[i] <= '0;
            m_gen <= '0; m_genreq <= 0; m_valid <= 0; m_a0 <= 0; m_a1 <= 0; m_d <= '0;
            pend <= '0;
        end else begin
            if (cfg_we && !mc[1][31])
                mc[cfg_sel] <= cfg_sel[0] ? (cfg_wdata & 32'h9F77FFFF) : cfg_wdata;
            if (!m_valid || msg_ready) begin
                if (m_genreq) begin
                    m_valid <= 1;
                    m_a0 <= compose(mc[1], mc[0], int'(m_gen[31:18]), 0);
                    m_a1 <= compose(mc[3], mc[2], int'(m_gen[31:18]), 0);
                    m_d  <= m_gen % 2048;
                end else if (s >= 0) begin
                    m_valid <= 1;
                    m_a0 <= compose(mc[1], mc[0], int'(tgt[s][31:18]), 0);
                    m_a1 <= compose(mc[3], mc[2], int'(tgt[s][31:18]), int'(tgt[s][17:12]));
                    m_d  <= tgt[s] % 2048;
                end else begin
                    m_valid <= 0;
                end
            end
            if (gen_we) m_genreq <= 1;
            else if ((!m_valid || msg_ready) && m_genreq) m_genreq <= 0;
            if (gen_we) m_gen <= gen_wdata & 32'hFFFC0FFF;
            pend <= (pend & ~((s >= 0) ? NS'(1) << s : NS'(0))) | set_req;
        end
    end

    task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare both instances with the model shortly after every rising edge.
    always @(posedge clk) begin
        int s;
        #1;
        if (started && !done) begin
            s = pick_src();
            chk(cur_req, "u0 valid", v0, m_valid);
            chk(cur_req, "u1 valid", v1, m_valid);
            chk("R7", "u0 clr", clr0, (s >= 0) ? (1 << s) : 0);
            chk("R7", "u1 clr", clr1, (s >= 0) ? (1 << s) : 0);
            chk("R8", "gen_word", gw0, m_gen);
            chk("R8", "gen_word u1", gw1, m_gen);
            if (m_valid) begin
                chk(cur_req, "u0 addr", a0, m_a0);
                chk("R6", "u1 addr", a1, m_a1);
                chk("R5", "u0 data", d0, m_d);
                chk("R5", "u1 data", d1, m_d);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(logic [1:0] sel, logic [31:0] val);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        tick(1);
        cfg_we = 0;
    endtask

    task automatic wgen(logic [31:0] val);
        gen_we = 1; gen_wdata = val;
        tick(1);
        gen_we = 0;
    endtask

    task automatic raise(logic [NS-1:0] m);
        set_req = m;
        tick(1);
        set_req = '0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        for (int i = 0; i < NS; i++)
            tgt[i] = {14'(i*37 + 5 + i*1200), 6'(i*11 + 1), 1'b1, 11'(i*100 + 3)};
        tick(1);
        started = 1;
        tick(4);
        rst_n = 1;
        tick(1);
        // R1: reset state at the ports
        chk("R1", "valid after reset", v0, 0);
        chk("R1", "gen_word after reset", gw0, 0);
        chk("R1", "clr after reset", clr0, 0);

        // R4 / R2: first layout, junk bits 30,29,23,19 set
        cur_req = "R2";
        wcfg(2'd0, 32'h0008_0000);
        wcfg(2'd1, 32'h6088_0000 | (4 << 24) | (3 << 20) | (2 << 16) | (2 << 12) | 32'h123);
        wcfg(2'd2, 32'h0010_0000);
        wcfg(2'd3, (10 << 24) | (6 << 20) | (1 << 16) | (3 << 12) | 32'h0AB);
        dom_ie = 1; src_en = '1; msg_ready = 1;
        for (int i = 0; i < NS; i++) begin
            raise(NS'(1) << i);
            tick(2);
        end

        // R4: sweep of layouts
        cur_req = "R4";
        for (int k = 0; k < 6; k++) begin
            wcfg(2'd1, ((k*5 + 1) % 32) << 24 | (k % 8) << 20 | ((k + 1) % 8) << 16 |
                       ((k*3) % 16) << 12 | ((k*32'h111) & 32'hFFF));
            wcfg(2'd3, ((k*7 + 3) % 32) << 24 | ((k + 2) % 8) << 20 | ((k*3) % 8) << 16 |
                       ((k*5 + 1) % 16) << 12 | ((k*32'h2A5) & 32'hFFF));
            wcfg(2'd0, 32'h1234_5000 + k);
            raise('1);
            tick(12);
        end

        // R7: gating and lowest-index order
        cur_req = "R7";
        dom_ie = 0;
        raise(8'h0F);
        tick(5);
        src_en = 8'h0A;
        tick(2);
        dom_ie = 1;
        tick(6);
        src_en = '1;
        tick(6);

        // R9: backpressure
        cur_req = "R9";
        msg_ready = 0;
        raise(8'hF0);
        tick(6);
        for (int c = 0; c < 20; c++) begin
            msg_ready = c[0];
            tick(1);
        end
        msg_ready = 1;
        tick(6);

        // R8: software message overtakes pending sources
        cur_req = "R8";
        msg_ready = 0;
        raise(8'h03);
        tick(2);
        wgen({14'h2ABC, 6'h3F, 1'b1, 11'h5A5});
        tick(3);
        msg_ready = 1;
        tick(6);

        // R10: last software write wins
        cur_req = "R10";
        msg_ready = 0;
        raise(8'h01);
        tick(1);
        wgen({14'h0011, 6'h15, 1'b0, 11'h111});
        wgen({14'h1FFF, 6'h2A, 1'b0, 11'h7FF});
        tick(3);
        msg_ready = 1;
        tick(6);

        // R3: lock freezes all four words
        cur_req = "R3";
        wcfg(2'd1, 32'h8000_0000 | (2 << 24) | (1 << 20) | (3 << 16) | (4 << 12) | 32'h777);
        wcfg(2'd0, 32'hDEAD_B000);
        wcfg(2'd1, 32'h0000_0000);
        wcfg(2'd2, 32'hCAFE_0000);
        wcfg(2'd3, 32'h1F7F_FFFF);
        raise('1);
        tick(12);
        chk("R3", "lock still set", mc[1][31], 1);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule